// File: doc/BRIEF.md
# IQ Sample UDP Framer

This block takes a stream of complex baseband samples and turns it into complete Ethernet frames that carry UDP datagrams. Each frame goes out as a byte stream to an Ethernet MAC. The MAC appends the frame check sequence and drives the line. Each frame has three parts, in this order:

- a 42-byte header covering Ethernet, IPv4 and UDP;
- a 64-bit packet sequence number;
- a fixed block of 366 complex samples.

Each 13-bit I or Q component is widened to a 16-bit field by sign extension. This keeps every component on a byte boundary, with no bit packing and no truncation.

The MAC and IP addresses and the UDP ports come from configuration inputs, which must stay stable while a frame is in flight. The IPv4 header checksum is computed from those inputs and from the fixed header fields. The UDP checksum field is sent as zero.

The sample input uses a valid/ready handshake. A sample is taken only when the output accepts the byte that carries its I low byte. This means that header bytes and output backpressure stall the sample source, and no sample is lost.

Top module: `iq_udp_framer`

## Requirements
- R1: After reset the first byte offered has out_sop set, equals the first destination MAC byte, and out_valid is high while in_ready is low.
- R2: Frame bytes 0 to 13 are the destination MAC, then the source MAC (each most significant byte first), then the type 0x08,0x00.
- R3: Frame bytes 14 to 33 are an IPv4 header, most significant byte first, with these fields: version/IHL 0x45, TOS 0x00, total length 1500 (0x05DC), identification 0x0000, flags 0x4000 (don't fragment), TTL 64, protocol 17, then the source IP and the destination IP.
- R4: Frame bytes 24 and 25 hold the IPv4 header checksum, high byte first. It is the ones' complement of the ones'-complement sum of the header's ten 16-bit words, with the checksum word itself taken as zero.
- R5: Frame bytes 34 to 41 carry the UDP header, most significant byte first: source port, destination port, length 1480 (0x05C8), then checksum 0x0000.
- R6: Frame bytes 42 to 49 carry a 64-bit packet number, least significant byte first. It is 0 for the first frame after reset and rises by one for each frame.
- R7: From byte 50 onward the frame carries exactly 366 samples of four bytes each, in this order: I low, I high, Q low, Q high. Each component is sign-extended from 13 to 16 bits, and samples appear in the order they were accepted.
- R8: Every frame is 1514 bytes long. out_sop is set only on byte 0 and out_eop only on byte 1513, and the byte after an end-of-frame byte starts a new frame.
- R9: in_ready is high only on the first byte of a sample slot and only while out_ready is high. During the header and the packet number it is low, and a taken sample is never followed by in_ready in the next cycle.
- R10: While out_valid is high and out_ready is low, out_data, out_sop and out_eop hold their values and the frame position does not advance. out_valid is high on every byte except the first byte of a sample slot, where it follows in_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_dst_mac | input | 48 | Destination MAC address |
| cfg_src_mac | input | 48 | Source MAC address |
| cfg_src_ip | input | 32 | Source IPv4 address |
| cfg_dst_ip | input | 32 | Destination IPv4 address |
| cfg_src_port | input | 16 | UDP source port |
| cfg_dst_port | input | 16 | UDP destination port |
| in_valid | input | 1 | Sample valid |
| in_ready | output | 1 | Sample accepted when high together with in_valid |
| in_i | input | 13 | In-phase component, two's complement |
| in_q | input | 13 | Quadrature component, two's complement |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the byte |
| out_data | output | 8 | Output byte |
| out_sop | output | 1 | First byte of a frame |
| out_eop | output | 1 | Last byte of a frame |

## Verification
The output byte is decoded from the registered frame position without a further register, so each byte is due in the same cycle it is offered. The next byte is due one cycle after a cycle in which out_valid and out_ready were both high. The I low byte appears in the same cycle as its input handshake. The bench applies inputs on the falling edge and samples 2 ns later. It compares the offered byte with the head of the expected queue in every cycle where out_valid is high, and pops the queue only when the byte is accepted. This way, stalled cycles and accepted cycles are checked at the exact position the design should be on.

// File: rtl/iqf_pkg.sv
// Shared constants and types for the IQ UDP framer.
// Assumes a plain IPv4 header (no options) and a fixed-size datagram.
package iqf_pkg;
    localparam int ETH_HDR     = 14;
    localparam int IP_HDR      = 20;
    localparam int UDP_HDR     = 8;
    localparam int HDR_BYTES   = ETH_HDR + IP_HDR + UDP_HDR;
    localparam int WORD_W      = 16;
    localparam int SLOT_BYTES  = 4;
    localparam logic [15:0] ETYPE_IPV4 = 16'h0800;
    localparam logic [7:0]  PROTO_UDP  = 8'h11;
    localparam logic [15:0] IP_FLAGS   = 16'h4000;

    typedef enum logic [1:0] {
        PH_HDR  = 2'd0,
        PH_ID   = 2'd1,
        PH_SAMP = 2'd2
    } phase_t;
endpackage

// File: rtl/iqf_ip_cksum.sv
// IPv4 header checksum over the fixed header words and the two addresses.
// Assumes a 20-byte header with zero identification and fixed flags.
module iqf_ip_cksum #(
    parameter logic [15:0] IP_LEN = 16'd1500,
    parameter logic [7:0]  TTL    = 8'd64
) (
    input  logic [31:0] src_ip,
    input  logic [31:0] dst_ip,
    output logic [15:0] cksum
);
    import iqf_pkg::*;

    logic [31:0] sum;
    logic [16:0] fold1;
    logic [15:0] fold2;

    // Sum the header words, then fold the carries back in twice.
    always_comb begin
        sum = 32'h4500 + 32'(IP_LEN) + 32'h0000 + 32'(IP_FLAGS)
            + 32'({TTL, PROTO_UDP})
            + 32'(src_ip[31:16]) + 32'(src_ip[15:0])
            + 32'(dst_ip[31:16]) + 32'(dst_ip[15:0]);
        fold1 = 17'(sum[15:0]) + 17'(sum[31:16]);
        fold2 = fold1[15:0] + 16'(fold1[16]);
        cksum = ~fold2;
    end
endmodule

// File: rtl/iqf_hdr_gen.sv
// Builds the 42-byte Ethernet/IPv4/UDP header and picks one byte by index.
// Assumes the configuration inputs stay stable while a frame is sent.
module iqf_hdr_gen #(
    parameter logic [15:0] IP_LEN  = 16'd1500,
    parameter logic [15:0] UDP_LEN = 16'd1480,
    parameter logic [7:0]  TTL     = 8'd64,
    parameter int          IDX_W   = 6
) (
    input  logic [47:0]      dst_mac,
    input  logic [47:0]      src_mac,
    input  logic [31:0]      src_ip,
    input  logic [31:0]      dst_ip,
    input  logic [15:0]      src_port,
    input  logic [15:0]      dst_port,
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       hdr_byte
);
    import iqf_pkg::*;

    localparam int VEC_W = HDR_BYTES * 8;

    logic [15:0]      ip_ck;
    logic [VEC_W-1:0] hdr_vec;
    logic [VEC_W-1:0] hdr_sh;

    iqf_ip_cksum #(.IP_LEN(IP_LEN), .TTL(TTL)) u_cksum (
        .src_ip (src_ip),
        .dst_ip (dst_ip),
        .cksum  (ip_ck)
    );

    // Concatenate the header in wire order and shift the wanted byte to the top.
    always_comb begin
        hdr_vec = {dst_mac, src_mac, ETYPE_IPV4,
                   8'h45, 8'h00, IP_LEN, 16'h0000, IP_FLAGS,
                   TTL, PROTO_UDP, ip_ck, src_ip, dst_ip,
                   src_port, dst_port, UDP_LEN, 16'h0000};
        hdr_sh   = hdr_vec << {idx, 3'b000};
        hdr_byte = hdr_sh[VEC_W-1 -: 8];
    end
endmodule

// File: rtl/iqf_seq_ctr.sv
// Frame byte position and packet number; both move only on an accepted byte.
// Assumes step is high only when a byte leaves the block.
module iqf_seq_ctr #(
    parameter int FRAME_BYTES = 1514,
    parameter int ID_W        = 64,
    parameter int POS_W       = $clog2(FRAME_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [POS_W-1:0] pos,
    output logic [ID_W-1:0]  pkt_id,
    output logic             last
);
    assign last = (pos == POS_W'(FRAME_BYTES - 1));

    // Advance the position each accepted byte; wrap and count frames at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos    <= '0;
            pkt_id <= '0;
        end else if (step) begin
            if (last) begin
                pos    <= '0;
                pkt_id <= pkt_id + 1'b1;
            end else begin
                pos <= pos + 1'b1;
            end
        end
    end

    // R6
    id_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && last) |=> (pkt_id == $past(pkt_id) + 1'b1));

    // R10
    pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(pos));
endmodule

// File: rtl/iq_udp_framer.sv
// Frames IQ samples into Ethernet/IPv4/UDP frames as a byte stream.
// Assumes configuration is stable during a frame; output is decoded from
// the registered position, and a sample is taken with its first byte.
module iq_udp_framer #(
    parameter int          N_SAMP = 366,
    parameter int          COMP_W = 13,
    parameter int          ID_W   = 64,
    parameter logic [7:0]  TTL    = 8'd64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [47:0]       cfg_dst_mac,
    input  logic [47:0]       cfg_src_mac,
    input  logic [31:0]       cfg_src_ip,
    input  logic [31:0]       cfg_dst_ip,
    input  logic [15:0]       cfg_src_port,
    input  logic [15:0]       cfg_dst_port,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [COMP_W-1:0] in_i,
    input  logic [COMP_W-1:0] in_q,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_data,
    output logic              out_sop,
    output logic              out_eop
);
    import iqf_pkg::*;

    localparam int ID_BYTES  = ID_W / 8;
    localparam int PAY_BYTES = ID_BYTES + N_SAMP * SLOT_BYTES;
    localparam int UDP_LEN   = UDP_HDR + PAY_BYTES;
    localparam int IP_LEN    = IP_HDR + UDP_LEN;
    localparam int FRAME     = HDR_BYTES + PAY_BYTES;
    localparam int SAMP_BASE = HDR_BYTES + ID_BYTES;
    localparam int POS_W     = $clog2(FRAME);
    localparam int HIDX_W    = $clog2(HDR_BYTES);
    localparam int ISEL_W    = $clog2(ID_BYTES);

    logic [POS_W-1:0]  pos;
    logic [ID_W-1:0]   pkt_id;
    logic              last;
    logic [7:0]        hdr_byte;
    logic [ID_W-1:0]   id_sh;
    logic [ISEL_W-1:0] id_sel;
    logic [1:0]        slot;
    logic              slot0;
    phase_t            phase;
    logic [WORD_W-1:0] i_ext_in;
    logic [WORD_W-1:0] i_hold;
    logic [WORD_W-1:0] q_hold;
    logic              fire;

    iqf_seq_ctr #(.FRAME_BYTES(FRAME), .ID_W(ID_W), .POS_W(POS_W)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (fire),
        .pos    (pos),
        .pkt_id (pkt_id),
        .last   (last)
    );

    iqf_hdr_gen #(
        .IP_LEN (16'(IP_LEN)),
        .UDP_LEN(16'(UDP_LEN)),
        .TTL    (TTL),
        .IDX_W  (HIDX_W)
    ) u_hdr (
        .dst_mac  (cfg_dst_mac),
        .src_mac  (cfg_src_mac),
        .src_ip   (cfg_src_ip),
        .dst_ip   (cfg_dst_ip),
        .src_port (cfg_src_port),
        .dst_port (cfg_dst_port),
        .idx      (pos[HIDX_W-1:0]),
        .hdr_byte (hdr_byte)
    );

    // Decode the frame phase and the byte slot inside a sample.
    always_comb begin
        if (pos < POS_W'(HDR_BYTES))      phase = PH_HDR;
        else if (pos < POS_W'(SAMP_BASE)) phase = PH_ID;
        else                              phase = PH_SAMP;
        id_sel   = pos[ISEL_W-1:0] - ISEL_W'(HDR_BYTES % ID_BYTES);
        slot     = pos[1:0] - 2'(SAMP_BASE % SLOT_BYTES);
        slot0    = (phase == PH_SAMP) && (slot == 2'd0);
        i_ext_in = {{(WORD_W-COMP_W){in_i[COMP_W-1]}}, in_i};
        id_sh    = pkt_id >> {id_sel, 3'b000};
    end

    // Handshakes: a sample is taken only together with its first byte.
    assign out_valid = slot0 ? in_valid : 1'b1;
    assign in_ready  = slot0 && out_ready;
    assign fire      = out_valid && out_ready;
    assign out_sop   = (pos == '0);
    assign out_eop   = last;

    // Select the byte for the current position.
    always_comb begin
        unique case (phase)
            PH_HDR:  out_data = hdr_byte;
            PH_ID:   out_data = id_sh[7:0];
            default: begin
                unique case (slot)
                    2'd0:    out_data = i_ext_in[7:0];
                    2'd1:    out_data = i_hold[15:8];
                    2'd2:    out_data = q_hold[7:0];
                    default: out_data = q_hold[15:8];
                endcase
            end
        endcase
    end

    // Hold the sign-extended sample for its remaining three bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            i_hold <= '0;
            q_hold <= '0;
        end else if (in_valid && in_ready) begin
            i_hold <= i_ext_in;
            q_hold <= {{(WORD_W-COMP_W){in_q[COMP_W-1]}}, in_q};
        end
    end

    // R8
    eop_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_eop) |=> out_sop);

    // R9
    ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> out_ready);

    // R9
    samp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !slot0) |=>
            ($stable(out_data) && $stable(out_sop) && $stable(out_eop)));
endmodule

// File: tb/iq_udp_framer_tb.sv
// Scoreboard bench: a driver task queues the expected bytes of each frame,
// a monitor compares every offered byte with the head of the queue.
module iq_udp_framer_tb;
    localparam int NS     = 366;
    localparam int FRAMES = 3;
    localparam int FLEN   = 1514;
    localparam int SBASE  = 50;

    localparam logic [47:0] DMAC  = 48'h02_11_22_33_44_55;
    localparam logic [47:0] SMAC  = 48'h02_AA_BB_CC_DD_EE;
    localparam logic [31:0] SIP   = 32'hC0A8_010A;
    localparam logic [31:0] DIP   = 32'hC0A8_0164;
    localparam logic [15:0] SPORT = 16'h1388;
    localparam logic [15:0] DPORT = 16'h1389;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [12:0] in_i = '0;
    logic [12:0] in_q = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [7:0]  out_data;
    logic        out_sop;
    logic        out_eop;

    int total = 0;
    int bad = 0;
    int in_idx = 0;
    int popped = 0;
    bit done = 1'b0;
    bit go = 1'b0;
    logic [12:0] si [NS*FRAMES];
    logic [12:0] sq [NS*FRAMES];
    logic [9:0]  q_exp [$];

    always #4 clk = ~clk;

    iq_udp_framer u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_dst_mac(DMAC), .cfg_src_mac(SMAC),
        .cfg_src_ip(SIP), .cfg_dst_ip(DIP),
        .cfg_src_port(SPORT), .cfg_dst_port(DPORT),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_i(in_i), .in_q(in_q),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop)
    );

    function automatic logic [15:0] ip_ck();
        logic [31:0] s;
        s = 32'h4500 + 32'h05DC + 32'h4000 + 32'h4011
          + 32'(SIP[31:16]) + 32'(SIP[15:0]) + 32'(DIP[31:16]) + 32'(DIP[15:0]);
        while (s[31:16] != 0) s = 32'(s[15:0]) + 32'(s[31:16]);
        return ~s[15:0];
    endfunction

    function automatic logic [7:0] exp_byte(int f, int p);
        logic [15:0] e;
        logic [63:0] id;
        int k;
        if (p < 6)  return DMAC[8*(5-p) +: 8];
        if (p < 12) return SMAC[8*(11-p) +: 8];
        if (p >= 26 && p < 30) return SIP[8*(29-p) +: 8];
        if (p >= 30 && p < 34) return DIP[8*(33-p) +: 8];
        if (p >= 42 && p < 50) begin
            id = 64'(f);
            return id[8*(p-42) +: 8];
        end
        if (p >= SBASE) begin
            k = f*NS + (p-SBASE)/4;
            case ((p-SBASE) % 4)
                0: begin e = {{3{si[k][12]}}, si[k]}; return e[7:0];  end
                1: begin e = {{3{si[k][12]}}, si[k]}; return e[15:8]; end
                2: begin e = {{3{sq[k][12]}}, sq[k]}; return e[7:0];  end
                default: begin e = {{3{sq[k][12]}}, sq[k]}; return e[15:8]; end
            endcase
        end
        case (p)
            12: return 8'h08;  13: return 8'h00;  14: return 8'h45;
            15: return 8'h00;  16: return 8'h05;  17: return 8'hDC;
            18: return 8'h00;  19: return 8'h00;  20: return 8'h40;
            21: return 8'h00;  22: return 8'h40;  23: return 8'h11;
            24: return ip_ck() >> 8;  25: return ip_ck() & 16'hFF;
            34: return SPORT[15:8];   35: return SPORT[7:0];
            36: return DPORT[15:8];   37: return DPORT[7:0];
            38: return 8'h05;  39: return 8'hC8;
            default: return 8'h00;
        endcase
    endfunction

    function automatic string tag_of(int p);
        if (p < 14) return "R2";
        if (p == 24 || p == 25) return "R4";
        if (p < 34) return "R3";
        if (p < 42) return "R5";
        if (p < 50) return "R6";
        return "R7";
    endfunction

    // Driver: queue every byte of frame f with its start/end flags.
    task automatic push_frame(int f);
        for (int p = 0; p < FLEN; p++)
            q_exp.push_back({p == 0, p == FLEN-1, exp_byte(f, p)});
    endtask

    task automatic check(bit ok, string tag, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s pos=%0d actual=%0h expected=%0h", tag, popped % FLEN, act, expv);
        end
    endtask

    // Stimulus: reset, reset-state check, then random valid/ready each falling edge.
    initial begin
        for (int k = 0; k < NS*FRAMES; k++) begin
            si[k] = 13'($urandom);
            sq[k] = 13'($urandom);
        end
        si[0] = 13'h0FFF; sq[0] = 13'h1000;
        si[1] = 13'h0000; sq[1] = 13'h1FFF;
        for (int f = 0; f < FRAMES; f++) push_frame(f);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1: reset state
        check(out_sop === 1'b1 && out_valid === 1'b1, "R1", {out_sop, out_valid}, 2'b11);
        check(out_data === DMAC[47:40], "R1", out_data, DMAC[47:40]);
        check(in_ready === 1'b0, "R1", in_ready, 0);
        go = 1'b1;
        while (!done) begin
            @(negedge clk);
            out_ready = ($urandom % 5) != 0;
            in_valid  = (in_idx < NS*FRAMES) && (($urandom % 4) != 0);
            in_i = (in_idx < NS*FRAMES) ? si[in_idx] : '0;
            in_q = (in_idx < NS*FRAMES) ? sq[in_idx] : '0;
        end
    end

    // Monitor: compare offered bytes with the queue head, pop on acceptance.
    always @(negedge clk) begin
        if (go && !done) begin
            int p;
            logic [9:0] h;
            #2;
            p = popped % FLEN;
            // R9: ready only in the first byte of a sample slot with out_ready high
            check(in_ready === (p >= SBASE && (p-SBASE) % 4 == 0 && out_ready), "R9",
                  in_ready, (p >= SBASE && (p-SBASE) % 4 == 0 && out_ready));
            if (!(p >= SBASE && (p-SBASE) % 4 == 0))
                check(out_valid === 1'b1, "R10", out_valid, 1);
            if (out_valid && q_exp.size() > 0) begin
                h = q_exp[0];
                check(out_data === h[7:0], out_ready ? tag_of(p) : "R10", out_data, h[7:0]);
                check({out_sop, out_eop} === h[9:8], "R8", {out_sop, out_eop}, h[9:8]);
                if (out_ready) begin
                    void'(q_exp.pop_front());
                    popped++;
                    if (in_valid && in_ready) in_idx++;
                end
            end
            if (q_exp.size() == 0) done = 1'b1;
        end
    end

    // Watchdog and summary.
    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog popped=%0d actual=%0d expected=%0d", popped, popped, FLEN*FRAMES);
        end
        #10;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule